// File: doc/BRIEF.md
# Operand Collector with Immediate Bypass

This block is the operand-gathering stage of a computation unit. It sits between a register file and an ALU pipeline. An instruction is handed to it with a single-cycle issue handshake. The block then asks the register file for each source operand on a separate request line. It captures each operand in the cycle its grant arrives, and once every slot holds a value it offers the whole operand set to the ALU on a valid/ready interface.

For integer and logical pipelines, two per-instruction flags let operands bypass the register file. The zero flag makes slot 0 an all-zero operand. The immediate flag makes slot 1 the immediate that came with the instruction. In both cases the register read for that slot is never requested, so no read port bandwidth is used. A build parameter removes both bypass paths for other pipeline types. In that build every slot always reads the register file.

Back-pressure rules: issue is accepted only on a cycle where `iss_valid_i` and `iss_ready_o` are both high. `iss_ready_o` is low for the whole time an instruction is held. Once raised, `alu_valid_o` stays high with unchanged operands until the cycle where `alu_ready_i` is high. The unit becomes free on the following cycle.

Top module: `opcoll_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `busy_o` low, every `rd_req_o` bit low, `alu_valid_o` low and `iss_ready_o` high.
- R2: `iss_ready_o` equals not-busy. An issue is taken only when `iss_valid_i` and `iss_ready_o` are both high. `iss_valid_i` while busy has no effect on requests or operands, and the flags and immediate are sampled only at the accepting edge.
- R3: After an accepted issue, every slot that is not substituted has its `rd_req_o` bit high from the next cycle. The bit stays high until a cycle with the matching `rd_gnt_i` high, and it is low in the cycle after that grant. A grant on a slot whose request is low is ignored.
- R4: The value on a slot's `rd_data_i` field (bits `[i*W +: W]`) in its grant cycle is the value that slot later presents on `alu_src_o` (same field position).
- R5: With substitution built in and `iss_zero_a_i` high at issue, slot 0 is presented as all zeros and `rd_req_o[0]` is never raised for that instruction.
- R6: With substitution built in and `iss_imm_ok_i` high at issue, slot 1 is presented as `iss_imm_i` and `rd_req_o[1]` is never raised for that instruction.
- R7: Zero substitution affects only slot 0 and immediate substitution affects only slot 1. Slots 2 and up always request and deliver their granted data.
- R8: A substituted slot counts as ready from the cycle after issue. `alu_valid_o` rises in the cycle after the last outstanding grant, or in the cycle after issue when no slot needs a read.
- R9: `alu_valid_o`, once high, stays high with `alu_src_o` stable until `alu_ready_i` is high. In the next cycle `busy_o` and `alu_valid_o` are low and `iss_ready_o` is high.
- R10: With `HAS_SUBST` = 0, both flags are ignored: all slots request their register and deliver granted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | Unit can take an issue |
| iss_zero_a_i | input | 1 | Force slot 0 to zero |
| iss_imm_ok_i | input | 1 | Use immediate for slot 1 |
| iss_imm_i | input | W | Immediate value |
| busy_o | output | 1 | An instruction is held |
| rd_req_o | output | NSRC | Per-slot register read request |
| rd_gnt_i | input | NSRC | Per-slot read grant |
| rd_data_i | input | NSRC*W | Read data, slot i at bits [i*W +: W] |
| alu_valid_o | output | 1 | Operand set offered to ALU |
| alu_ready_i | input | 1 | ALU accepts operand set |
| alu_src_o | output | NSRC*W | Operands, slot i at bits [i*W +: W] |

## Verification
Instructions are issued with all four combinations of the zero and immediate flags. Comparing which request lines rise tells suppressed reads from real ones, and comparing the delivered operands tells substituted values from granted data. Grant latency per slot is randomised, including grants in the issue-following cycle and long waits. This separates a correct latch-on-grant from one that samples early or late. Spurious grants on idle slots and issue pulses while busy are mixed in, and ALU back-pressure of random length checks that the offered set holds steady. A second build without substitution is given both flags set, to show that they are then ignored.

// File: rtl/opcoll_pkg.sv
package opcoll_pkg;

  typedef enum logic [1:0] {
    SUB_NONE = 2'd0,
    SUB_ZERO = 2'd1,
    SUB_IMM  = 2'd2
  } subst_e;

  // Which bypass path, if any, a given operand slot owns.
  function automatic subst_e slot_kind(input int idx, input bit has_subst);
    if (!has_subst) return SUB_NONE;
    if (idx == 0) return SUB_ZERO;
    if (idx == 1) return SUB_IMM;
    return SUB_NONE;
  endfunction

endpackage

// File: rtl/opcoll_slot.sv
module opcoll_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_i,
  input  logic         sub_flag_i,
  input  logic [W-1:0] sub_val_i,
  input  logic         release_i,
  input  logic         gnt_i,
  input  logic [W-1:0] data_i,
  output logic         req_o,
  output logic         ready_o,
  output logic [W-1:0] opnd_o
);

  logic         req_q;
  logic         ready_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      ready_q <= 1'b0;
      data_q  <= '0;
    end else if (issue_i) begin
      if (sub_flag_i) begin
        // Bypass: value is known now, no register read is requested.
        data_q  <= sub_val_i;
        ready_q <= 1'b1;
        req_q   <= 1'b0;
      end else begin
        ready_q <= 1'b0;
        req_q   <= 1'b1;
      end
    end else if (release_i) begin
      ready_q <= 1'b0;
      req_q   <= 1'b0;
    end else if (req_q && gnt_i) begin
      data_q  <= data_i;
      ready_q <= 1'b1;
      req_q   <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign ready_o = ready_q;
  assign opnd_o  = data_q;

endmodule

// File: rtl/opcoll_ctrl.sv
module opcoll_ctrl #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid_i,
  input  logic [NSRC-1:0] slot_ready_i,
  input  logic            alu_ready_i,
  output logic            iss_ready_o,
  output logic            accept_o,
  output logic            release_o,
  output logic            busy_o,
  output logic            alu_valid_o
);

  logic busy_q;
  logic all_ready;

  assign all_ready   = &slot_ready_i;
  assign iss_ready_o = !busy_q;
  assign accept_o    = iss_valid_i && !busy_q;
  assign alu_valid_o = busy_q && all_ready;
  assign release_o   = alu_valid_o && alu_ready_i;

  always_ff @(posedge clk) begin
    if (rst)            busy_q <= 1'b0;
    else if (accept_o)  busy_q <= 1'b1;
    else if (release_o) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/opcoll_unit.sv
module opcoll_unit
  import opcoll_pkg::*;
#(
  parameter int NSRC      = 3,
  parameter int W         = 64,
  parameter bit HAS_SUBST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  input  logic              iss_zero_a_i,
  input  logic              iss_imm_ok_i,
  input  logic [W-1:0]      iss_imm_i,
  output logic              busy_o,
  output logic [NSRC-1:0]   rd_req_o,
  input  logic [NSRC-1:0]   rd_gnt_i,
  input  logic [NSRC*W-1:0] rd_data_i,
  output logic              alu_valid_o,
  input  logic              alu_ready_i,
  output logic [NSRC*W-1:0] alu_src_o
);

  localparam int BUS_W = NSRC * W;

  logic            accept;
  logic            release_set;
  logic [NSRC-1:0] slot_ready;
  logic [NSRC-1:0] sub_flag;
  logic [BUS_W-1:0] sub_val;

  opcoll_ctrl #(.NSRC(NSRC)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .iss_valid_i  (iss_valid_i),
    .slot_ready_i (slot_ready),
    .alu_ready_i  (alu_ready_i),
    .iss_ready_o  (iss_ready_o),
    .accept_o     (accept),
    .release_o    (release_set),
    .busy_o       (busy_o),
    .alu_valid_o  (alu_valid_o)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_slot
    localparam subst_e KIND = slot_kind(gi, HAS_SUBST);

    if (KIND == SUB_ZERO) begin : g_zero
      assign sub_flag[gi]          = iss_zero_a_i;
      assign sub_val[gi*W +: W]    = '0;
    end else if (KIND == SUB_IMM) begin : g_imm
      assign sub_flag[gi]          = iss_imm_ok_i;
      assign sub_val[gi*W +: W]    = iss_imm_i;
    end else begin : g_none
      assign sub_flag[gi]          = 1'b0;
      assign sub_val[gi*W +: W]    = '0;
    end

    opcoll_slot #(.W(W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .issue_i    (accept),
      .sub_flag_i (sub_flag[gi]),
      .sub_val_i  (sub_val[gi*W +: W]),
      .release_i  (release_set),
      .gnt_i      (rd_gnt_i[gi]),
      .data_i     (rd_data_i[gi*W +: W]),
      .req_o      (rd_req_o[gi]),
      .ready_o    (slot_ready[gi]),
      .opnd_o     (alu_src_o[gi*W +: W])
    );
  end

endmodule

// File: rtl/opcoll_chk.sv
module opcoll_chk #(
  parameter int NSRC      = 3,
  parameter int W         = 64,
  parameter bit HAS_SUBST = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid_i,
  input logic              iss_ready_o,
  input logic              iss_zero_a_i,
  input logic              iss_imm_ok_i,
  input logic [W-1:0]      iss_imm_i,
  input logic              busy_o,
  input logic [NSRC-1:0]   rd_req_o,
  input logic [NSRC-1:0]   rd_gnt_i,
  input logic [NSRC*W-1:0] rd_data_i,
  input logic              alu_valid_o,
  input logic              alu_ready_i,
  input logic [NSRC*W-1:0] alu_src_o
);

  // R1: state after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && rd_req_o == '0 && !alu_valid_o));

  // R2: busy only ever begins from an offered issue
  p_busy_from_issue_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(iss_valid_i));

  // R3: a pending request without grant stays up
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o & ~rd_gnt_i) != '0 |=> (($past(rd_req_o & ~rd_gnt_i) & ~rd_req_o) == '0));

  // R3: a granted request is down the next cycle
  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o & rd_gnt_i) != '0 |=> (($past(rd_req_o & rd_gnt_i) & rd_req_o) == '0));

  // R3: requests only while holding an instruction
  p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o != '0) |-> busy_o);

  // R9: offered set is held under back-pressure
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (alu_valid_o && !alu_ready_i) |=> (alu_valid_o && $stable(alu_src_o)));

  // R9: handshake frees the unit
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (alu_valid_o && alu_ready_i) |=> (!busy_o && !alu_valid_o));

  if (HAS_SUBST) begin : g_sub
    // R5: zero flag suppresses slot 0 read
    p_zero_noreq_r5: assert property (@(posedge clk) disable iff (rst)
      (iss_valid_i && iss_ready_o && iss_zero_a_i) |=> !rd_req_o[0]);

    // R6: immediate flag suppresses slot 1 read
    p_imm_noreq_r6: assert property (@(posedge clk) disable iff (rst)
      (iss_valid_i && iss_ready_o && iss_imm_ok_i) |=> !rd_req_o[1]);

    // R6: immediate delivered on slot 1 right after issue
    p_imm_value_r6: assert property (@(posedge clk) disable iff (rst)
      (iss_valid_i && iss_ready_o && iss_imm_ok_i) |=> (alu_src_o[W +: W] == $past(iss_imm_i)));
  end else begin : g_nosub
    // R10: every slot reads after issue
    p_all_req_r10: assert property (@(posedge clk) disable iff (rst)
      (iss_valid_i && iss_ready_o) |=> (rd_req_o == '1));
  end

endmodule

bind opcoll_unit opcoll_chk #(.NSRC(NSRC), .W(W), .HAS_SUBST(HAS_SUBST)) u_chk (.*);

// File: tb/tb_opcoll_unit.sv
`timescale 1ns/1ps
module tb_opcoll_unit;

  localparam int N  = 3;
  localparam int W  = 64;
  localparam int N2 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // substituting build
  logic           iss_valid = 0, iss_zero = 0, iss_imm_ok = 0;
  logic [W-1:0]   iss_imm = '0;
  logic           iss_ready, busy, alu_valid, alu_ready = 0;
  logic [N-1:0]   rd_req, rd_gnt = '0;
  logic [N*W-1:0] rd_data = '0, alu_src;

  opcoll_unit #(.NSRC(N), .W(W), .HAS_SUBST(1'b1)) dut (
    .clk(clk), .rst(rst), .iss_valid_i(iss_valid), .iss_ready_o(iss_ready),
    .iss_zero_a_i(iss_zero), .iss_imm_ok_i(iss_imm_ok), .iss_imm_i(iss_imm),
    .busy_o(busy), .rd_req_o(rd_req), .rd_gnt_i(rd_gnt), .rd_data_i(rd_data),
    .alu_valid_o(alu_valid), .alu_ready_i(alu_ready), .alu_src_o(alu_src));

  // plain build
  logic            p_iss_valid = 0, p_zero = 0, p_imm_ok = 0;
  logic [W-1:0]    p_imm = '0;
  logic            p_iss_ready, p_busy, p_alu_valid, p_alu_ready = 0;
  logic [N2-1:0]   p_req, p_gnt = '0;
  logic [N2*W-1:0] p_data = '0, p_src;

  opcoll_unit #(.NSRC(N2), .W(W), .HAS_SUBST(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .iss_valid_i(p_iss_valid), .iss_ready_o(p_iss_ready),
    .iss_zero_a_i(p_zero), .iss_imm_ok_i(p_imm_ok), .iss_imm_i(p_imm),
    .busy_o(p_busy), .rd_req_o(p_req), .rd_gnt_i(p_gnt), .rd_data_i(p_data),
    .alu_valid_o(p_alu_valid), .alu_ready_i(p_alu_ready), .alu_src_o(p_src));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // expected operand for a slot given the issue flags
  function automatic logic [W-1:0] exp_opnd(input int s, input bit za, input bit io,
                                            input logic [W-1:0] imm, input logic [W-1:0] dat);
    if (s == 0 && za) return '0;
    if (s == 1 && io) return imm;
    return dat;
  endfunction

  function automatic bit is_sub(input int s, input bit za, input bit io);
    return (s == 0 && za) || (s == 1 && io);
  endfunction

  task automatic run_instr(input bit za, input bit io, input logic [W-1:0] imm,
                           input int max_dly, input int bp_cycles, input bit noise);
    logic [W-1:0] exp_op [N];
    bit           rdy [N];
    bit           pend [N];
    int           dly [N];
    bit           allr;
    int           guard;
    @(negedge clk);
    chk(iss_ready == 1'b1, "R2 iss_ready idle", W'(iss_ready), 64'd1);
    iss_valid = 1; iss_zero = za; iss_imm_ok = io; iss_imm = imm;
    for (int s = 0; s < N; s++) begin
      rdy[s] = is_sub(s, za, io);
      exp_op[s] = exp_opnd(s, za, io, imm, '0);
      dly[s] = $urandom_range(max_dly, 0);
      pend[s] = 0;
    end
    @(negedge clk);
    // scramble issue inputs: they must not matter now (R2)
    iss_valid = 0; iss_zero = ~za; iss_imm_ok = ~io; iss_imm = rnd64();
    chk(busy == 1'b1, "R2 busy after issue", W'(busy), 64'd1);
    chk(iss_ready == 1'b0, "R2 iss_ready while busy", W'(iss_ready), 64'd0);
    for (int s = 0; s < N; s++)
      chk(rd_req[s] == !rdy[s], $sformatf("R3/R5/R6/R7 req slot %0d after issue", s),
          W'(rd_req[s]), W'(!rdy[s]));
    allr = 1;
    for (int s = 0; s < N; s++) allr &= rdy[s];
    chk(alu_valid == allr, "R8 valid after issue", W'(alu_valid), W'(allr));
    guard = 0;
    while (!allr && guard < 200) begin
      guard++;
      for (int s = 0; s < N; s++) begin
        if (!rdy[s]) begin
          if (dly[s] == 0) begin
            rd_gnt[s] = 1; rd_data[s*W +: W] = rnd64();
            exp_op[s] = rd_data[s*W +: W]; pend[s] = 1;
          end else dly[s]--;
        end else if (noise && $urandom_range(1, 0) == 1) begin
          rd_gnt[s] = 1; rd_data[s*W +: W] = rnd64();  // must be ignored (R3)
        end
      end
      if (noise && $urandom_range(3, 0) == 0) begin
        iss_valid = 1; iss_zero = $urandom_range(1, 0); iss_imm_ok = $urandom_range(1, 0);
      end
      @(negedge clk);
      rd_gnt = '0; rd_data = '0; iss_valid = 0;
      allr = 1;
      for (int s = 0; s < N; s++) begin
        if (pend[s]) begin rdy[s] = 1; pend[s] = 0; end
        allr &= rdy[s];
        chk(rd_req[s] == !rdy[s], $sformatf("R3 req slot %0d", s), W'(rd_req[s]), W'(!rdy[s]));
      end
      chk(alu_valid == allr, "R8 valid timing", W'(alu_valid), W'(allr));
    end
    for (int b = 0; b <= bp_cycles; b++) begin
      if (b == bp_cycles) alu_ready = 1;
      chk(alu_valid == 1'b1, "R9 valid held", W'(alu_valid), 64'd1);
      for (int s = 0; s < N; s++)
        chk(alu_src[s*W +: W] == exp_op[s],
            $sformatf("R4/R5/R6/R7 operand slot %0d", s), alu_src[s*W +: W], exp_op[s]);
      @(negedge clk);
    end
    alu_ready = 0;
    chk(busy == 1'b0, "R9 busy cleared", W'(busy), 64'd0);
    chk(alu_valid == 1'b0, "R9 valid cleared", W'(alu_valid), 64'd0);
    chk(iss_ready == 1'b1, "R9 iss_ready back", W'(iss_ready), 64'd1);
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] d0, d1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && rd_req == '0 && alu_valid == 0 && iss_ready == 1,
        "R1 reset state", {59'd0, busy, rd_req, alu_valid}, 64'd0);
    chk(p_busy == 0 && p_req == '0 && p_alu_valid == 0 && p_iss_ready == 1,
        "R1 reset state plain", {60'd0, p_busy, p_req, p_alu_valid}, 64'd0);

    // directed corners
    run_instr(0, 0, 64'h1111_2222_3333_4444, 0, 0, 0);   // all reads, immediate grants
    run_instr(1, 0, 64'hDEAD_BEEF_0000_0001, 3, 2, 0);   // zero only (R5)
    run_instr(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 0);   // immediate only (R6)
    run_instr(1, 1, 64'h0123_4567_89AB_CDEF, 0, 0, 0);   // both; only slot 2 reads (R7, R8)
    run_instr(1, 1, 64'h8000_0000_0000_0000, 6, 4, 1);   // long wait with noise

    // random mix
    for (int k = 0; k < 60; k++)
      run_instr($urandom_range(1, 0), $urandom_range(1, 0), rnd64(),
                $urandom_range(5, 0), $urandom_range(3, 0), 1);

    // R10: plain build ignores the flags
    @(negedge clk);
    p_iss_valid = 1; p_zero = 1; p_imm_ok = 1; p_imm = 64'hAAAA_5555_AAAA_5555;
    @(negedge clk);
    p_iss_valid = 0;
    chk(p_req == 2'b11, "R10 both slots request", W'(p_req), 64'd3);
    d0 = rnd64(); d1 = rnd64();
    p_gnt = 2'b11; p_data = {d1, d0};
    @(negedge clk);
    p_gnt = '0; p_data = '0;
    chk(p_alu_valid == 1'b1, "R10 valid after grants", W'(p_alu_valid), 64'd1);
    chk(p_src[0 +: W] == d0, "R10 slot 0 data not zero", p_src[0 +: W], d0);
    chk(p_src[W +: W] == d1, "R10 slot 1 data not immediate", p_src[W +: W], d1);
    p_alu_ready = 1;
    @(negedge clk);
    p_alu_ready = 0;
    chk(p_busy == 1'b0, "R10 released", W'(p_busy), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule